// File: doc/BRIEF.md
# Dual-Direction Storing Bus Transceiver

This block moves a multi-bit word between an A side and a B side, with one path for each direction. Each path holds its word in one storage register. The path's own controls pick the storage mode. With the latch enable high, the register follows its input on every system cycle, which gives a transparent path. With the latch enable low, the register keeps its value until a falling edge on the path's own strobe clock loads a new word. That load happens only while the path's active-low clock enable is asserted.

Each path has an active-low output enable. It drives a separate drive-enable output, which the surrounding pad logic uses to turn the pins on or off. This lets a tri-state bus be modelled and checked without inout ports. The whole block runs on one system clock. The strobe clocks, latch enables, clock enables and output enables are all sampled as ordinary inputs on that clock. Both the stored word and the drive enable are registered. Every effect therefore shows at the outputs one system cycle after the edge that samples its cause.

Top module: `dual_path_xcvr`

## Requirements
- R1: The data width is a parameter with default 18. The A-to-B path (a_in to b_out) and the B-to-A path (b_in to a_out) each have their own output enable, latch enable, strobe clock and clock enable.
- R2: When a path's output enable is low at a system edge, its drive-enable output is 1 after that edge. When it is high, the drive enable is 0, meaning high impedance. The data output keeps the stored word in both cases.
- R3: While a path's latch enable is high at a system edge, the path's output after that edge equals the input sampled at that edge (transparent mode).
- R4: With latch enable low and clock enable low, a falling edge on the strobe clock loads the input word. The falling edge is detected when a system edge sees the strobe low after the previous system edge saw it high. The word sampled at that edge is loaded and appears on the output after it.
- R5: With latch enable low and no strobe falling edge, the stored word holds. This covers a strobe held high, a strobe held low, and a strobe rising edge.
- R6: While the clock enable is high, strobe falling edges have no effect and the stored word holds.
- R7: When latch enable goes low with the strobe high, the output keeps the last word passed in transparent mode.
- R8: A synchronous active-high reset clears both stored words to 0 and both drive enables to 0.
- R9: The two paths operate concurrently. Controls and data of one path never change the other path's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Word received from the A side |
| b_in | input | W | Word received from the B side |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable |
| ab_clk | input | 1 | A-to-B strobe clock, loads on falling edge |
| ab_cen_n | input | 1 | A-to-B strobe clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_clk | input | 1 | B-to-A strobe clock, loads on falling edge |
| ba_cen_n | input | 1 | B-to-A strobe clock enable, active low |
| b_out | output | W | Word driven onto the B side |
| b_den | output | 1 | Drive enable for the B-side pins |
| a_out | output | W | Word driven onto the A side |
| a_den | output | 1 | Drive enable for the A-side pins |

## Verification
The bench targets the points where the storage modes meet.

- The latch enable falls while the strobe is high. A design that let a later input leak through would show the new word instead of the retained one.
- A strobe rising edge and a long low strobe are applied with the clock enable asserted. A design that loaded on any level or on the rising edge would change its output there.
- A falling edge arrives while the clock enable is deasserted. A design that ignored the enable would load that word.
- The output enable is toggled. The bench checks that only the drive enable moves and that the stored word stays valid.
- Both paths run at once in different modes. This would expose any crossing of data or controls between paths.

// File: rtl/dpx_pkg.sv
`timescale 1ns/1ps
package dpx_pkg;
  localparam int unsigned DPX_W = 18;
  localparam int unsigned DPX_NDIR = 2;

  typedef struct packed {
    logic oe_n;
    logic le;
    logic dclk;
    logic cen_n;
  } dpx_ctrl_t;
endpackage

// File: rtl/dpx_fall_det.sv
`timescale 1ns/1ps
module dpx_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic dclk_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= dclk_i;
  end

  assign fall_o = prev_q & ~dclk_i;

  AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && fall_o |-> $past(dclk_i)); // R4
endmodule

// File: rtl/dpx_store.sv
`timescale 1ns/1ps
module dpx_store #(
  parameter int unsigned W = dpx_pkg::DPX_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  input  logic         le_i,
  input  logic         fall_i,
  input  logic         cen_n_i,
  output logic [W-1:0] q_o
);
  logic load;

  assign load = le_i | (fall_i & ~cen_n_i);

  always_ff @(posedge clk) begin
    if (rst)       q_o <= '0;
    else if (load) q_o <= d_i;
  end

  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(le_i) |-> q_o == $past(d_i)); // R3
  AST_EDGE_LOAD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(le_i) && $past(fall_i) && !$past(cen_n_i) |-> q_o == $past(d_i)); // R4
  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(le_i) && !$past(fall_i) |-> $stable(q_o)); // R5
  AST_CEN_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(le_i) && $past(cen_n_i) |-> $stable(q_o)); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> q_o == '0); // R8
endmodule

// File: rtl/dpx_dir.sv
`timescale 1ns/1ps
module dpx_dir #(
  parameter int unsigned W = dpx_pkg::DPX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [W-1:0]        d_i,
  input  dpx_pkg::dpx_ctrl_t  ctrl_i,
  output logic [W-1:0]        q_o,
  output logic                den_o
);
  logic fall;

  dpx_fall_det i_fall (
    .clk    (clk),
    .rst    (rst),
    .dclk_i (ctrl_i.dclk),
    .fall_o (fall)
  );

  dpx_store #(.W(W)) i_store (
    .clk     (clk),
    .rst     (rst),
    .d_i     (d_i),
    .le_i    (ctrl_i.le),
    .fall_i  (fall),
    .cen_n_i (ctrl_i.cen_n),
    .q_o     (q_o)
  );

  always_ff @(posedge clk) begin
    if (rst) den_o <= 1'b0;
    else     den_o <= ~ctrl_i.oe_n;
  end

  AST_HIZ_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_i.oe_n) |-> !den_o); // R2
  AST_DRIVE_WHEN_ON: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(ctrl_i.oe_n) |-> den_o); // R2
  AST_RESET_OFF: assert property (@(posedge clk)
    rst |=> !den_o); // R8
endmodule

// File: rtl/dual_path_xcvr.sv
`timescale 1ns/1ps
module dual_path_xcvr #(
  parameter int unsigned W = dpx_pkg::DPX_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_cen_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_cen_n,
  output logic [W-1:0] b_out,
  output logic         b_den,
  output logic [W-1:0] a_out,
  output logic         a_den
);
  localparam int unsigned NDIR = dpx_pkg::DPX_NDIR;

  logic [NDIR-1:0][W-1:0]         din;
  logic [NDIR-1:0][W-1:0]         dout;
  logic [NDIR-1:0]                den;
  dpx_pkg::dpx_ctrl_t [NDIR-1:0]  ctrl;

  // index 0: A to B, index 1: B to A (R1)
  assign din[0]  = a_in;
  assign din[1]  = b_in;
  assign ctrl[0] = '{oe_n: ab_oe_n, le: ab_le, dclk: ab_clk, cen_n: ab_cen_n};
  assign ctrl[1] = '{oe_n: ba_oe_n, le: ba_le, dclk: ba_clk, cen_n: ba_cen_n};

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    dpx_dir #(.W(W)) i_dir (
      .clk    (clk),
      .rst    (rst),
      .d_i    (din[g]),
      .ctrl_i (ctrl[g]),
      .q_o    (dout[g]),
      .den_o  (den[g])
    );
  end

  assign b_out = dout[0];
  assign b_den = den[0];
  assign a_out = dout[1];
  assign a_den = den[1];

  AST_PATH_ISOLATION: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(ab_le) && $past(ab_cen_n) |-> $stable(b_out)); // R9
endmodule

// File: tb/test_dual_path_xcvr.sv
`timescale 1ns/1ps
module test_dual_path_xcvr;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, b_in;
  logic ab_oe_n, ab_le, ab_clk, ab_cen_n;
  logic ba_oe_n, ba_le, ba_clk, ba_cen_n;
  logic [W-1:0] b_out, a_out;
  logic b_den, a_den;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_path_xcvr #(.W(W)) i_dual_path_xcvr (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_cen_n(ab_cen_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_cen_n(ba_cen_n),
    .b_out(b_out), .b_den(b_den), .a_out(a_out), .a_den(a_den)
  );

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(2);
    check("R8 b_out", b_out, '0);
    check("R8 a_out", a_out, '0);
    check("R8 b_den", {17'b0, b_den}, 18'd0);
    check("R8 a_den", {17'b0, a_den}, 18'd0);
    rst = 1'b0;
  endtask

  task automatic t_transparent();
    ab_le = 1'b1; ab_clk = 1'b1; a_in = 18'h2A5C3;
    tick();
    check("R3 follow 1", b_out, 18'h2A5C3);
    a_in = 18'h15A3C;
    tick();
    check("R3 follow 2", b_out, 18'h15A3C);
  endtask

  task automatic t_latch_retain();
    a_in = 18'h0BEEF; tick();
    ab_le = 1'b0; a_in = 18'h3FFFF;
    tick();
    check("R7 retain", b_out, 18'h0BEEF);
    tick(3);
    check("R7 retain later", b_out, 18'h0BEEF);
  endtask

  task automatic t_hold();
    ab_cen_n = 1'b0; a_in = 18'h12345;
    tick(3);
    check("R5 clock high steady", b_out, 18'h0BEEF);
    ab_cen_n = 1'b1; ab_clk = 1'b0; tick();
    ab_cen_n = 1'b0; a_in = 18'h22222;
    tick(3);
    check("R5 clock low steady", b_out, 18'h0BEEF);
    ab_clk = 1'b1; tick();
    check("R5 rising edge", b_out, 18'h0BEEF);
  endtask

  task automatic t_capture();
    a_in = 18'h31337; ab_clk = 1'b0;
    tick();
    check("R4 capture on fall", b_out, 18'h31337);
    a_in = 18'h00001;
    tick(2);
    check("R4 hold after capture", b_out, 18'h31337);
  endtask

  task automatic t_cen_block();
    ab_clk = 1'b1; tick();
    ab_cen_n = 1'b1; a_in = 18'h2DEAD; ab_clk = 1'b0;
    tick(2);
    check("R6 fall blocked", b_out, 18'h31337);
    ab_cen_n = 1'b0;
  endtask

  task automatic t_output_enable();
    ab_oe_n = 1'b0; tick();
    check("R2 drive on", {17'b0, b_den}, 18'd1);
    check("R2 data valid", b_out, 18'h31337);
    ab_oe_n = 1'b1; tick();
    check("R2 hi-z", {17'b0, b_den}, 18'd0);
    check("R2 data kept", b_out, 18'h31337);
  endtask

  task automatic t_concurrent();
    ab_le = 1'b1; ab_oe_n = 1'b0; a_in = 18'h11111;
    ba_le = 1'b0; ba_cen_n = 1'b0; ba_clk = 1'b1; ba_oe_n = 1'b0; b_in = 18'h2C0DE;
    tick();
    ba_clk = 1'b0;
    tick();
    check("R9 ab transparent", b_out, 18'h11111);
    check("R9 ba captured", a_out, 18'h2C0DE);
    check("R1 ba drive", {17'b0, a_den}, 18'd1);
    b_in = 18'h00F0F; a_in = 18'h0ABCD;
    tick();
    check("R9 ba holds", a_out, 18'h2C0DE);
    check("R9 ab follows", b_out, 18'h0ABCD);
    ab_le = 1'b0; ab_cen_n = 1'b1; ba_le = 1'b1; b_in = 18'h3A0A0;
    tick();
    check("R9 ab untouched", b_out, 18'h0ABCD);
    check("R1 ba transparent", a_out, 18'h3A0A0);
  endtask

  initial begin
    rst = 1'b1; a_in = '0; b_in = '0;
    ab_oe_n = 1'b1; ab_le = 1'b0; ab_clk = 1'b1; ab_cen_n = 1'b1;
    ba_oe_n = 1'b1; ba_le = 1'b0; ba_clk = 1'b1; ba_cen_n = 1'b1;
    t_reset();
    t_transparent();
    t_latch_retain();
    t_hold();
    t_capture();
    t_cen_block();
    t_output_enable();
    t_concurrent();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule